// File: doc/BRIEF.md
# Clock Power-Mode Controller

This block derives the processor clocks from a double-rate input clock and moves them between full speed and three low-power modes. In the normal running mode the input clock is halved to give a 50% duty processor clock on two outputs: one for the CPU and bus logic (core) and one for the peripherals. In power-save mode both clocks are slowed down by a selectable ratio. In idle mode only the core clock stops. In powerdown mode both clocks stop and the oscillator enable drops. A wake-up from powerdown re-enables the oscillator and then waits out a programmable startup count before the clocks come back.

Software picks a mode with one register write that carries the mode code, the slow-down ratio and the wake delay. Writes land only while the core clock runs. An NMI or an unmasked interrupt brings the block back to full speed from power-save, idle or powerdown. Every stopped clock rests at logic 0. A clock starts and stops only on whole phases, so no shortened pulse ever appears on an output.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: While reset is low, both clocks are 0, osc_en is 1 and run_ok is 1. The first core_clk rise comes at the first clk_in edge after reset is released, so the divided clock is realigned on every reset release.
- R2: In run mode (cfg_mode 00, also the mode after reset), core_clk and periph_clk each stay high for one clk_in cycle and low for one clk_in cycle.
- R3: Power-save mode (cfg_mode 01) uses cfg_div to pick the ratio N: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. Both clocks are then high for N clk_in cycles and low for N clk_in cycles.
- R4: A new ratio takes effect only at the start of a high phase. Every high pulse on core_clk lasts 1, 4, 8 or 16 clk_in cycles, including the pulses around a change of ratio.
- R5: In power-save mode, nmi or irq_unmasked returns the block to run mode. A write made during power-save with cfg_mode 01 and a new cfg_div is accepted.
- R6: In idle mode (cfg_mode 10), core_clk stays 0 while periph_clk keeps toggling. nmi or irq_unmasked returns the block to run mode.
- R7: In powerdown mode (cfg_mode 11), core_clk and periph_clk stay 0, osc_en is 0 and run_ok is 0.
- R8: When nmi or irq_unmasked arrives in powerdown, osc_en is 1 after the next clk_in edge. run_ok rises exactly D clk_in edges after that edge, where D is the cfg_wake value given with the powerdown write (0 counts as 1). Both clocks stay 0 until then.
- R9: Writes are ignored in idle, powerdown and during the wake delay. irq_unmasked has no effect in run mode. In power-save, a wake event in the same cycle as a write takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Double-rate input clock |
| rst_n | input | 1 | Active-low reset |
| nmi | input | 1 | Non-maskable interrupt request, wake event |
| irq_unmasked | input | 1 | An unmasked interrupt is pending, wake event |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_mode | input | 2 | Requested mode: 00 run, 01 power-save, 10 idle, 11 powerdown |
| cfg_div | input | 2 | Power-save ratio code |
| cfg_wake | input | WAKE_W | Wake delay in clk_in cycles |
| core_clk | output | 1 | Gated CPU and bus clock |
| periph_clk | output | 1 | Gated peripheral clock |
| osc_en | output | 1 | Oscillator enable |
| run_ok | output | 1 | Core clock is running |

## Verification
Pulse widths are measured in every mode: run mode, all four power-save ratios, and a switch of ratio made inside power-save. Comparing both the high and the low width tells a wrong ratio decode apart from a duty-cycle error. A width outside the legal set during a change shows a runt pulse. The idle and powerdown tests count rising edges on each clock separately, which tells which clock was gated. The wake test checks the exact edge on which run_ok rises. The ignored writes, interrupts in run mode and the same-cycle wake-and-write case are each followed by a pulse-width measurement, which shows at the ports which mode the block actually took.

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl #(
  parameter int WAKE_W = 8
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              nmi,
  input  logic              irq_unmasked,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_div,
  input  logic [WAKE_W-1:0] cfg_wake,
  output logic              core_clk,
  output logic              periph_clk,
  output logic              osc_en,
  output logic              run_ok
);

  typedef enum logic [2:0] {S_RUN, S_SAVE, S_IDLE, S_PDOWN, S_WAKE} pm_t;

  pm_t               st;
  logic [1:0]        div_q;
  logic [WAKE_W-1:0] wake_q, wcnt;
  logic              bclk;
  logic [4:0]        half_q, half_nx, cnt;

  wire wake_ev  = nmi | irq_unmasked;
  wire running  = (st == S_RUN) || (st == S_SAVE);
  wire edge_hit = (cnt == half_q - 5'd1);

  assign osc_en = (st != S_PDOWN);
  assign run_ok = running;

  always_comb begin
    case (div_q)
      2'd0:    half_nx = 5'd1;
      2'd1:    half_nx = 5'd4;
      2'd2:    half_nx = 5'd8;
      default: half_nx = 5'd16;
    endcase
    if (st != S_SAVE) half_nx = 5'd1;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      div_q  <= 2'd0;
      wake_q <= '1;
      wcnt   <= '0;
    end else begin
      case (st)
        S_RUN: if (cfg_we) begin
          st     <= pm_t'({1'b0, cfg_mode});
          div_q  <= cfg_div;
          wake_q <= cfg_wake;
        end
        S_SAVE: if (wake_ev) st <= S_RUN;
          else if (cfg_we) begin
            st     <= pm_t'({1'b0, cfg_mode});
            div_q  <= cfg_div;
            wake_q <= cfg_wake;
          end
        S_IDLE: if (wake_ev) st <= S_RUN;
        S_PDOWN: if (wake_ev) begin
          st   <= S_WAKE;
          wcnt <= (wake_q == '0) ? WAKE_W'(1) : wake_q;
        end
        default: if (wcnt <= WAKE_W'(1)) st <= S_RUN;
          else wcnt <= wcnt - WAKE_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      bclk       <= 1'b0;
      cnt        <= '0;
      half_q     <= 5'd1;
      core_clk   <= 1'b0;
      periph_clk <= 1'b0;
    end else if (edge_hit) begin
      cnt  <= '0;
      bclk <= ~bclk;
      if (!bclk) begin
        half_q     <= half_nx;
        core_clk   <= running;
        periph_clk <= running || (st == S_IDLE);
      end else begin
        core_clk   <= 1'b0;
        periph_clk <= 1'b0;
      end
    end else begin
      cnt <= cnt + 5'd1;
    end
  end

  a_r6_core_rise_running: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(core_clk) |-> ($past(st) == S_RUN || $past(st) == S_SAVE));

  a_r7_periph_rise_awake: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(periph_clk) |-> ($past(st) != S_PDOWN && $past(st) != S_WAKE));

  a_r8_osc_before_run: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(run_ok) |-> $past(osc_en));

  a_r4_ratio_at_rise: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(half_q) |-> bclk);

  a_r2_core_within_periph: assert property (@(posedge clk_in) disable iff (!rst_n)
    core_clk |-> periph_clk);

endmodule

// File: tb/clk_pwr_ctrl_tb.sv
module clk_pwr_ctrl_tb_top;
  localparam int WAKE_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, nmi = 1'b0, irq = 1'b0, we = 1'b0;
  logic [1:0] mode = 2'd0, div = 2'd0;
  logic [WAKE_W-1:0] wake = '0;
  logic core_clk, periph_clk, osc_en, run_ok;

  int checks = 0, failures = 0, runt_bad = 0;
  int exp_q[$];
  string cur_tag = "R2";
  bit sb_on = 1'b0, done = 1'b0;
  int hi_w = 0, lo_w = 0;
  bit prev = 1'b0;

  clk_pwr_ctrl #(.WAKE_W(WAKE_W)) dut_i (
    .clk_in(clk), .rst_n(rst_n), .nmi(nmi), .irq_unmasked(irq),
    .cfg_we(we), .cfg_mode(mode), .cfg_div(div), .cfg_wake(wake),
    .core_clk(core_clk), .periph_clk(periph_clk), .osc_en(osc_en), .run_ok(run_ok));

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures core_clk phases, pops expected widths
  always @(negedge clk) begin
    if (!rst_n) begin
      hi_w = 0; lo_w = 0; prev = 1'b0;
    end else begin
      if (core_clk) begin
        if (!prev) begin
          if (hi_w > 0 && sb_on && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            check(hi_w == e && lo_w == e, cur_tag, hi_w * 100 + lo_w, e * 100 + e);
          end
          hi_w = 0;
        end
        hi_w++;
      end else begin
        if (prev) begin
          if (!(hi_w == 1 || hi_w == 4 || hi_w == 8 || hi_w == 16)) begin
            runt_bad++;
            $display("FAIL R4 actual=%0d expected=1/4/8/16", hi_w);
          end
          lo_w = 0;
        end
        lo_w++;
      end
      prev = core_clk;
    end
  end

  task automatic write_cfg(logic [1:0] m, logic [1:0] d, logic [WAKE_W-1:0] w);
    @(negedge clk); we = 1'b1; mode = m; div = d; wake = w;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse(bit use_nmi);
    @(negedge clk); if (use_nmi) nmi = 1'b1; else irq = 1'b1;
    @(negedge clk); nmi = 1'b0; irq = 1'b0;
  endtask

  task automatic expect_widths(int n, int k, string tag);
    int guard = 0;
    sb_on = 1'b0;
    repeat (40) @(negedge clk);
    cur_tag = tag;
    for (int i = 0; i < k; i++) exp_q.push_back(n);
    sb_on = 1'b1;
    while (exp_q.size() > 0 && guard < 400) begin @(negedge clk); guard++; end
    check(exp_q.size() == 0, {tag, " pulses"}, exp_q.size(), 0);
    exp_q.delete();
    sb_on = 1'b0;
  endtask

  task automatic count_rises(int n, output int c_r, output int p_r);
    bit pc, pp;
    c_r = 0; p_r = 0; pc = core_clk; pp = periph_clk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (core_clk && !pc) c_r++;
      if (periph_clk && !pp) p_r++;
      pc = core_clk; pp = periph_clk;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cr, pr;
    repeat (3) @(negedge clk);
    check(!core_clk && !periph_clk && osc_en && run_ok, "R1 reset",
          {core_clk, periph_clk, osc_en, run_ok}, 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    check(core_clk == 1'b1, "R1 first rise", core_clk, 1);
    @(negedge clk);
    check(core_clk == 1'b0, "R1 second edge", core_clk, 0);

    expect_widths(1, 4, "R2 run");

    write_cfg(2'b01, 2'b01, '0);
    expect_widths(4, 3, "R3 div4");
    write_cfg(2'b01, 2'b11, '0);  // R4 ratio change inside save
    expect_widths(16, 2, "R3 div16");
    write_cfg(2'b01, 2'b10, '0);
    expect_widths(8, 2, "R3 div8");
    write_cfg(2'b01, 2'b00, '0);
    expect_widths(1, 3, "R3 div1");
    write_cfg(2'b01, 2'b01, '0);
    expect_widths(4, 1, "R5 save before irq");
    pulse(1'b0);
    expect_widths(1, 3, "R5 irq exit");
    write_cfg(2'b01, 2'b10, '0);
    pulse(1'b1);
    expect_widths(1, 3, "R5 nmi exit");

    pulse(1'b0);
    check(run_ok == 1'b1, "R9 irq in run", run_ok, 1);
    expect_widths(1, 3, "R9 irq in run");

    write_cfg(2'b01, 2'b10, '0);
    @(negedge clk); we = 1'b1; mode = 2'b10; nmi = 1'b1;
    @(negedge clk); we = 1'b0; nmi = 1'b0;
    check(run_ok == 1'b1, "R9 wake beats write", run_ok, 1);
    expect_widths(1, 3, "R9 wake beats write");

    write_cfg(2'b10, 2'b00, '0);
    repeat (10) @(negedge clk);
    count_rises(60, cr, pr);
    check(cr == 0, "R6 idle core", cr, 0);
    check(pr == 30, "R6 idle periph", pr, 30);
    write_cfg(2'b00, 2'b00, '0);
    count_rises(40, cr, pr);
    check(cr == 0, "R9 write in idle", cr, 0);
    pulse(1'b0);
    expect_widths(1, 3, "R6 idle exit");

    write_cfg(2'b11, 2'b00, WAKE_W'(5));
    repeat (10) @(negedge clk);
    check(!osc_en && !run_ok, "R7 pdown flags", {osc_en, run_ok}, 0);
    count_rises(40, cr, pr);
    check(cr == 0 && pr == 0, "R7 pdown clocks", cr + pr, 0);
    write_cfg(2'b00, 2'b00, '0);
    check(osc_en == 1'b0, "R9 write in pdown", osc_en, 0);

    @(negedge clk); irq = 1'b1;
    @(posedge clk);
    @(negedge clk); irq = 1'b0;
    check(osc_en && !run_ok, "R8 osc on", {osc_en, run_ok}, 2'b10);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!run_ok && !core_clk && !periph_clk, "R8 wait",
            {run_ok, core_clk, periph_clk}, 0);
    end
    @(negedge clk);
    check(run_ok == 1'b1, "R8 ready", run_ok, 1);
    expect_widths(1, 3, "R8 after wake");

    checks++;
    if (runt_bad != 0) begin
      failures++;
      $display("FAIL R4 runts actual=%0d expected=0", runt_bad);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule